// File: doc/BRIEF.md
# Sigma-Delta Mode and Calibration Sequencer

This block is the digital controller that sits between a sigma-delta modulator, its decimation filter and the register file. It holds the operating-mode code, the gain code and a filter-hold bit, all loaded through one register-write port. It counts the result strobes that the decimation filter produces. From that count it steers the analog input selector, fires single-cycle write enables into the offset and full-scale calibration registers and into the data register, and drives an active-low data-ready flag.

The one-shot calibrations run by themselves. Each one settles for a fixed number of filter periods and latches its result. It then puts the mode back to normal conversion and waits for the filter to settle again on the external input before it signals a new word. A background mode mixes offset measurements of the shorted input with conversions at a fixed ratio. The hold bit freezes all sequencing, and the block counts a fresh settling window once the bit is released.

Top module: `adc_cal_seq`

## Requirements
- R1: After synchronous reset: mode read-back 000, gain one-hot output 1 (code 0), filter hold low, data-ready flag `rdy_n` high, all write enables low, input select 0.
- R2: Mode codes 000 to 011 mean normal conversion. After any write, the first SETTLE (3) accepted strobes give one word on the SETTLE-th strobe and then one word on every later strobe. A word is a one-cycle `data_we` pulse in the cycle after the strobe edge, with `rdy_n` going low at the same edge. A `data_rd` pulse sets `rdy_n` high.
- R3: Input select encoding is 0 = external input, 1 = shorted input, 2 = reference divided by gain. Normal and system-offset (100) select 0. Zero-scale self-calibration (110) selects 1. Full-scale self-calibration (111) selects 2.
- R4: In modes 100 and 110 the SETTLE-th strobe raises `ofs_we` for one cycle. In mode 111 it raises `fs_we` for one cycle.
- R5: At that same edge a one-step calibration sets the mode read-back to 000 without a write. The next word follows after SETTLE more strobes.
- R6: A write of mode 100, 110 or 111 sets `rdy_n` high. It stays high until the first word after the calibration.
- R7: Background mode (101) repeats a group of 2*SETTLE strobes. The first SETTLE slots select the shorted input, and the last slot of that half raises `ofs_we`. The other slots select the external input, and the last slot of the group delivers a word. The mode stays 101.
- R8: While the hold bit is high, strobes cause no write enable and do not advance any calibration. After the bit is cleared, the first word comes on the SETTLE-th strobe.
- R9: The hold bit never raises `rdy_n`. Only `data_rd` or a one-step calibration write raises it.
- R10: `gain_val` is one-hot with bit n set for gain code n (gain 2^n, 1 to 128).
- R11: A write during a calibration aborts it and restarts the settling count in the new mode. No enable from the aborted mode follows.
- R12: At most one of `ofs_we`, `fs_we`, `data_we` is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe for mode, gain and hold fields |
| wr_mode | input | 3 | Mode code to write |
| wr_gain | input | GAIN_W | Gain code to write |
| wr_hold | input | 1 | Filter hold bit to write |
| flt_strobe | input | 1 | One-cycle pulse per decimation filter result |
| data_rd | input | 1 | Data register read pulse; sets rdy_n high |
| mode_rd | output | 3 | Current mode code |
| gain_val | output | 2**GAIN_W | One-hot gain value |
| flt_hold | output | 1 | Holds filter and calibration logic in reset |
| in_sel | output | 2 | Analog input select (0 ext, 1 shorted, 2 ref/gain) |
| ofs_we | output | 1 | Offset calibration register write enable |
| fs_we | output | 1 | Full-scale calibration register write enable |
| data_we | output | 1 | Data register write enable |
| rdy_n | output | 1 | Data-ready flag, low when a new word is available |

## Verification
The hardest situations to reach are a calibration aborted partway through its settling window and a hold raised while a calibration is pending. In both, a wrong design leaves a stale enable that only shows up strobes later. The bench issues a full-scale request, sends two strobes and then rewrites the mode to zero-scale. It checks that only an offset enable appears, and only on the third strobe after the rewrite. The background pattern is checked over two complete groups, with the input select sampled before every strobe, so a slot that is off by one in either half is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MD_NORMAL    = 3'b000;
   localparam logic [MODE_W-1:0] MD_SYS_OFS   = 3'b100;
   localparam logic [MODE_W-1:0] MD_BACKGND   = 3'b101;
   localparam logic [MODE_W-1:0] MD_ZERO_SELF = 3'b110;
   localparam logic [MODE_W-1:0] MD_FULL_SELF = 3'b111;

   localparam logic [1:0] SEL_EXT   = 2'd0;
   localparam logic [1:0] SEL_SHORT = 2'd1;
   localparam logic [1:0] SEL_REF   = 2'd2;

   function automatic logic is_one_step(input logic [MODE_W-1:0] m);
      return m[MODE_W-1] && (m != MD_BACKGND);
   endfunction
endpackage

// File: rtl/adc_mode_regs.sv
module adc_mode_regs
   import adc_seq_pkg::*;
#(
   parameter int GAIN_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic [GAIN_W-1:0] wr_gain,
   input  logic              wr_hold,
   input  logic              cal_done,
   output logic [MODE_W-1:0] mode_q,
   output logic [GAIN_W-1:0] gain_q,
   output logic              hold_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MD_NORMAL;
         gain_q <= '0;
         hold_q <= 1'b0;
      end else if (wr_en) begin
         mode_q <= wr_mode;
         gain_q <= wr_gain;
         hold_q <= wr_hold;
      end else if (cal_done) begin
         mode_q <= MD_NORMAL;
      end
   end
endmodule

// File: rtl/adc_strobe_ctr.sv
module adc_strobe_ctr #(
   parameter int LIMIT = 3,
   parameter bit WRAP  = 1'b0,
   localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          strobe,
   output logic [CW-1:0] cnt,
   output logic          at_last
);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   assign at_last = (cnt == LAST);

   generate
      if (WRAP) begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst || clr)        cnt <= '0;
            else if (strobe)       cnt <= at_last ? '0 : cnt + 1'b1;
         end
      end else begin : g_sat
         always_ff @(posedge clk) begin
            if (rst || clr)               cnt <= '0;
            else if (strobe && !at_last)  cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/adc_gain_dec.sv
module adc_gain_dec #(
   parameter int GAIN_W  = 3,
   localparam int GVAL_W = 1 << GAIN_W
) (
   input  logic [GAIN_W-1:0] gain_code,
   output logic [GVAL_W-1:0] gain_val
);
   generate
      for (genvar i = 0; i < GVAL_W; i++) begin : g_bit
         assign gain_val[i] = (gain_code == GAIN_W'(i));
      end
   endgenerate
endmodule

// File: rtl/adc_step_ctrl.sv
module adc_step_ctrl
   import adc_seq_pkg::*;
#(
   parameter int SETTLE = 3,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode_q,
   input  logic              hold,
   input  logic              strobe,
   input  logic              settle_last,
   input  logic [SLOT_W-1:0] slot_cnt,
   input  logic              slot_last,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic              data_rd,
   output logic              cal_done,
   output logic [1:0]        in_sel,
   output logic              ofs_we,
   output logic              fs_we,
   output logic              data_we,
   output logic              rdy_n
);
   localparam logic [SLOT_W-1:0] OFS_SLOT = SLOT_W'(SETTLE - 1);

   logic live, one_step, bg, norm;
   logic word_ev, ofs_ev, fs_ev, bg_ofs, bg_word;

   always_comb begin
      live     = strobe && !hold;
      one_step = is_one_step(mode_q);
      bg       = (mode_q == MD_BACKGND);
      norm     = !mode_q[MODE_W-1];
      cal_done = live && one_step && settle_last;
      bg_ofs   = live && bg && (slot_cnt == OFS_SLOT);
      bg_word  = live && bg && slot_last;
      ofs_ev   = (cal_done && (mode_q != MD_FULL_SELF)) || bg_ofs;
      fs_ev    = cal_done && (mode_q == MD_FULL_SELF);
      word_ev  = (live && norm && settle_last) || bg_word;
   end

   always_comb begin
      unique case (mode_q)
         MD_ZERO_SELF: in_sel = SEL_SHORT;
         MD_FULL_SELF: in_sel = SEL_REF;
         MD_BACKGND:   in_sel = (slot_cnt <= OFS_SLOT) ? SEL_SHORT : SEL_EXT;
         default:      in_sel = SEL_EXT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ofs_we  <= 1'b0;
         fs_we   <= 1'b0;
         data_we <= 1'b0;
         rdy_n   <= 1'b1;
      end else begin
         ofs_we  <= ofs_ev;
         fs_we   <= fs_ev;
         data_we <= word_ev;
         if (wr_en && is_one_step(wr_mode)) rdy_n <= 1'b1;
         else if (word_ev)                  rdy_n <= 1'b0;
         else if (data_rd)                  rdy_n <= 1'b1;
      end
   end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
   import adc_seq_pkg::*;
#(
   parameter int GAIN_W  = 3,
   parameter int SETTLE  = 3,
   localparam int GVAL_W   = 1 << GAIN_W,
   localparam int BG_GROUP = 2 * SETTLE,
   localparam int SLOT_W   = $clog2(BG_GROUP),
   localparam int SET_W    = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [2:0]        wr_mode,
   input  logic [GAIN_W-1:0] wr_gain,
   input  logic              wr_hold,
   input  logic              flt_strobe,
   input  logic              data_rd,
   output logic [2:0]        mode_rd,
   output logic [GVAL_W-1:0] gain_val,
   output logic              flt_hold,
   output logic [1:0]        in_sel,
   output logic              ofs_we,
   output logic              fs_we,
   output logic              data_we,
   output logic              rdy_n
);
   generate
      if (SETTLE < 1) begin : g_bad_settle
         $error("SETTLE must be at least 1");
      end
      if (GAIN_W < 1 || GAIN_W > 4) begin : g_bad_gain
         $error("GAIN_W must be in 1..4");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [GAIN_W-1:0] gain_q;
   logic              hold_q, hold, cal_done;
   logic [SET_W-1:0]  settle_cnt;
   logic              settle_last;
   logic [SLOT_W-1:0] slot_cnt;
   logic              slot_last;

   assign hold = wr_en || hold_q;

   adc_mode_regs #(.GAIN_W(GAIN_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode),
      .wr_gain(wr_gain), .wr_hold(wr_hold), .cal_done(cal_done),
      .mode_q(mode_q), .gain_q(gain_q), .hold_q(hold_q)
   );

   adc_strobe_ctr #(.LIMIT(SETTLE), .WRAP(1'b0)) u_settle (
      .clk(clk), .rst(rst), .clr(hold || cal_done), .strobe(flt_strobe),
      .cnt(settle_cnt), .at_last(settle_last)
   );

   adc_strobe_ctr #(.LIMIT(BG_GROUP), .WRAP(1'b1)) u_slot (
      .clk(clk), .rst(rst), .clr(hold || (mode_q != MD_BACKGND)),
      .strobe(flt_strobe), .cnt(slot_cnt), .at_last(slot_last)
   );

   adc_gain_dec #(.GAIN_W(GAIN_W)) u_gain (
      .gain_code(gain_q), .gain_val(gain_val)
   );

   adc_step_ctrl #(.SETTLE(SETTLE), .SLOT_W(SLOT_W)) u_ctrl (
      .clk(clk), .rst(rst), .mode_q(mode_q), .hold(hold),
      .strobe(flt_strobe), .settle_last(settle_last),
      .slot_cnt(slot_cnt), .slot_last(slot_last),
      .wr_en(wr_en), .wr_mode(wr_mode), .data_rd(data_rd),
      .cal_done(cal_done), .in_sel(in_sel), .ofs_we(ofs_we),
      .fs_we(fs_we), .data_we(data_we), .rdy_n(rdy_n)
   );

   assign mode_rd  = mode_q;
   assign flt_hold = hold_q;

   logic unused_settle;
   assign unused_settle = ^settle_cnt;
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
   parameter int GVAL_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [2:0]        wr_mode,
   input logic              data_rd,
   input logic [2:0]        mode_rd,
   input logic [GVAL_W-1:0] gain_val,
   input logic              flt_hold,
   input logic [1:0]        in_sel,
   input logic              ofs_we,
   input logic              fs_we,
   input logic              data_we,
   input logic              rdy_n
);
   // R12
   we_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ofs_we, fs_we, data_we}));

   // R2
   word_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
      data_we |-> !rdy_n);

   // R5
   fs_clears_mode_chk: assert property (@(posedge clk) disable iff (rst)
      fs_we |-> (mode_rd == 3'b000));

   // R3
   fs_uses_ref_chk: assert property (@(posedge clk) disable iff (rst)
      fs_we |-> ($past(in_sel) == 2'd2));

   // R8
   hold_blocks_we_chk: assert property (@(posedge clk) disable iff (rst)
      $past(flt_hold) |-> !(ofs_we || fs_we || data_we));

   // R9
   ready_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_n) |-> ($past(data_rd) ||
                        ($past(wr_en) && $past(wr_mode[2]) && ($past(wr_mode) != 3'b101))));

   // R10
   gain_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(gain_val) == 1);
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.GVAL_W(GVAL_W)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode),
   .data_rd(data_rd), .mode_rd(mode_rd), .gain_val(gain_val),
   .flt_hold(flt_hold), .in_sel(in_sel), .ofs_we(ofs_we),
   .fs_we(fs_we), .data_we(data_we), .rdy_n(rdy_n)
);

// File: tb/adc_cal_seq_tb.sv
module adc_cal_seq_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       wr_en = 1'b0;
   logic [2:0] wr_mode = '0;
   logic [2:0] wr_gain = '0;
   logic       wr_hold = 1'b0;
   logic       flt_strobe = 1'b0;
   logic       data_rd = 1'b0;
   logic [2:0] mode_rd;
   logic [7:0] gain_val;
   logic       flt_hold;
   logic [1:0] in_sel;
   logic       ofs_we, fs_we, data_we, rdy_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   adc_cal_seq u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode),
      .wr_gain(wr_gain), .wr_hold(wr_hold), .flt_strobe(flt_strobe),
      .data_rd(data_rd), .mode_rd(mode_rd), .gain_val(gain_val),
      .flt_hold(flt_hold), .in_sel(in_sel), .ofs_we(ofs_we),
      .fs_we(fs_we), .data_we(data_we), .rdy_n(rdy_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] m, input logic [2:0] g, input logic h);
      @(negedge clk);
      wr_en = 1'b1; wr_mode = m; wr_gain = g; wr_hold = h;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one strobe; checks the enables registered at its edge
   task automatic strobe(input logic eo, input logic ef, input logic ed, input string req);
      @(negedge clk);
      flt_strobe = 1'b1;
      @(posedge clk);
      #1;
      chk({req, " ofs_we"}, 32'(ofs_we), 32'(eo));
      chk({req, " fs_we"}, 32'(fs_we), 32'(ef));
      chk({req, " data_we"}, 32'(data_we), 32'(ed));
      @(negedge clk);
      flt_strobe = 1'b0;
      @(posedge clk);
      #1;
      chk({req, " R12 pulse width"}, 32'({ofs_we, fs_we, data_we}), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 mode", 32'(mode_rd), 32'd0);
      chk("R1 gain", 32'(gain_val), 32'h01);
      chk("R1 hold", 32'(flt_hold), 32'd0);
      chk("R1 rdy_n", 32'(rdy_n), 32'd1);
      chk("R1 we", 32'({ofs_we, fs_we, data_we}), 32'd0);
      chk("R1 in_sel", 32'(in_sel), 32'd0);
   endtask

   task automatic t_normal();
      strobe(0, 0, 0, "R2 s1");
      strobe(0, 0, 0, "R2 s2");
      strobe(0, 0, 1, "R2 s3");
      chk("R2 rdy low", 32'(rdy_n), 32'd0);
      strobe(0, 0, 1, "R2 s4");
      @(negedge clk); data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0;
      chk("R2 read sets rdy", 32'(rdy_n), 32'd1);
      wr(3'b011, 3'd0, 1'b0);
      chk("R2 mode 011", 32'(mode_rd), 32'd3);
      chk("R3 normal ext", 32'(in_sel), 32'd0);
      strobe(0, 0, 0, "R2 c1");
      strobe(0, 0, 0, "R2 c2");
      strobe(0, 0, 1, "R2 c3");
   endtask

   task automatic t_zero_self();
      chk("R6 pre rdy low", 32'(rdy_n), 32'd0);
      wr(3'b110, 3'd3, 1'b0);
      chk("R6 rdy high on start", 32'(rdy_n), 32'd1);
      chk("R3 shorted", 32'(in_sel), 32'd1);
      chk("R10 gain 8", 32'(gain_val), 32'h08);
      strobe(0, 0, 0, "R4 z1");
      strobe(0, 0, 0, "R4 z2");
      strobe(1, 0, 0, "R4 z3");
      chk("R5 mode back", 32'(mode_rd), 32'd0);
      chk("R6 still high", 32'(rdy_n), 32'd1);
      chk("R3 back ext", 32'(in_sel), 32'd0);
      strobe(0, 0, 0, "R5 n1");
      strobe(0, 0, 0, "R5 n2");
      strobe(0, 0, 1, "R5 n3");
      chk("R6 low after word", 32'(rdy_n), 32'd0);
   endtask

   task automatic t_full_self();
      wr(3'b111, 3'd7, 1'b0);
      chk("R3 ref", 32'(in_sel), 32'd2);
      chk("R10 gain 128", 32'(gain_val), 32'h80);
      strobe(0, 0, 0, "R4 f1");
      strobe(0, 0, 0, "R4 f2");
      strobe(0, 1, 0, "R4 f3");
      chk("R5 mode back", 32'(mode_rd), 32'd0);
   endtask

   task automatic t_sys_ofs();
      wr(3'b100, 3'd1, 1'b0);
      chk("R3 sys ext", 32'(in_sel), 32'd0);
      chk("R10 gain 2", 32'(gain_val), 32'h02);
      strobe(0, 0, 0, "R4 o1");
      strobe(0, 0, 0, "R4 o2");
      strobe(1, 0, 0, "R4 o3");
      chk("R5 mode back", 32'(mode_rd), 32'd0);
   endtask

   task automatic t_abort();
      wr(3'b111, 3'd0, 1'b0);
      strobe(0, 0, 0, "R11 a1");
      strobe(0, 0, 0, "R11 a2");
      wr(3'b110, 3'd0, 1'b0);
      chk("R11 new sel", 32'(in_sel), 32'd1);
      strobe(0, 0, 0, "R11 b1");
      strobe(0, 0, 0, "R11 b2");
      strobe(1, 0, 0, "R11 b3");
   endtask

   task automatic t_background();
      wr(3'b101, 3'd2, 1'b0);
      for (int g = 0; g < 2; g++) begin
         for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            chk("R7 in_sel", 32'(in_sel), (s < 3) ? 32'd1 : 32'd0);
            strobe(s == 2, 0, s == 5, "R7 slot");
         end
      end
      chk("R7 mode kept", 32'(mode_rd), 32'd5);
      chk("R7 rdy low", 32'(rdy_n), 32'd0);
   endtask

   task automatic t_hold();
      wr(3'b000, 3'd0, 1'b1);
      chk("R8 hold out", 32'(flt_hold), 32'd1);
      chk("R9 rdy stays low", 32'(rdy_n), 32'd0);
      for (int i = 0; i < 5; i++) strobe(0, 0, 0, "R8 held");
      chk("R9 rdy low after", 32'(rdy_n), 32'd0);
      wr(3'b000, 3'd0, 1'b0);
      strobe(0, 0, 0, "R8 r1");
      strobe(0, 0, 0, "R8 r2");
      strobe(0, 0, 1, "R8 r3");
      wr(3'b110, 3'd0, 1'b1);
      for (int i = 0; i < 4; i++) strobe(0, 0, 0, "R8 cal held");
      chk("R8 mode kept", 32'(mode_rd), 32'd6);
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      t_reset();
      t_normal();
      t_zero_self();
      t_full_self();
      t_sys_ofs();
      t_abort();
      t_background();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule